// File: doc/BRIEF.md
# HCI Transport Packet Delineator

This block sits on the receive side of a serial HCI transport. It takes a plain byte stream with a valid/ready handshake and cuts it into packets. Each packet opens with a one-byte type indicator. The block uses that indicator to pick the header layout, collects the header, pulls the declared length out of it, and then forwards exactly that many payload bytes.

Every packet leaves on a byte-wide output stream with these markers:
- a start-of-packet marker on its first byte;
- an end marker on its final byte;
- a two-bit side channel naming the packet kind.

The type indicator itself is not forwarded. The header bytes after it are forwarded.

In the idle state, a byte that is not a known indicator is consumed and dropped. This lets the parser regain lock after line noise. A data packet whose declared length is over the configured limit produces a one-cycle error pulse and no output, and the parser returns to hunting for the next indicator. Header bytes are held in a small register buffer until the length has been checked. Because of this, a rejected packet never puts a partial frame on the output.

Top module: `hci_pkt_delineator`

## Requirements
- R1: Out of reset the block accepts input (`in_ready_o`=1), presents no output (`out_valid_o`=0) and shows no error (`len_err_o`=0).
- R2: While hunting for a packet start, any byte other than 0x01, 0x02 or 0x04 is accepted and discarded, and nothing appears on the output.
- R3: Indicator 0x01 (command) is followed by a 3-byte header: opcode low byte, opcode high byte, then a one-byte parameter length L. The output is those 3 header bytes followed by L payload bytes, with `out_user_o`=0.
- R4: Indicator 0x04 (event) is followed by a 2-byte header: event code, then a one-byte length L. The output is those 2 header bytes followed by L payload bytes, with `out_user_o`=2.
- R5: Indicator 0x02 (ACL data) is followed by a 4-byte header: handle low byte, handle high byte, length low byte, length high byte. The length is little-endian 16-bit, carried at packet offsets 3 and 4. The output is the 4 header bytes plus that many payload bytes, with `out_user_o`=1.
- R6: `out_sof_o` is 1 on the first output byte of each packet (the first header byte) and 0 on all other bytes. `out_last_o` is 1 only on the final byte of a packet. For a zero-length packet, the final byte is the last header byte.
- R7: An ACL length above `MAX_ACL_LEN` (default 1024) raises `len_err_o` for exactly one cycle. No byte of that packet is output, and the block then hunts for a new indicator. A length equal to `MAX_ACL_LEN` is forwarded normally.
- R8: Under output backpressure no byte is lost or duplicated. While `out_valid_o`=1 and `out_ready_i`=0, `in_ready_o` is 0 and all output fields hold steady.
- R9: The type indicator byte is never forwarded. `out_user_o` keeps one value from the first to the last byte of a packet. The output carries nothing except the header and payload bytes of accepted packets.
- R10: While header bytes are being forwarded, no input byte is accepted (`in_ready_o`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block takes the input byte this cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte (header or payload) |
| out_sof_o | output | 1 | First byte of a packet |
| out_last_o | output | 1 | Final byte of a packet |
| out_user_o | output | 2 | Packet kind: 0 command, 1 ACL data, 2 event |
| out_ready_i | input | 1 | Downstream takes the output byte this cycle |
| len_err_o | output | 1 | One-cycle pulse on an oversize ACL length |

## Verification
The output-hold properties assume the upstream side keeps to the valid/ready rule. Once `in_valid_i` is raised it stays high with the same byte until `in_ready_o` takes it, because the payload path passes the input straight through to the output. The framing properties assume the block is the only source of the output stream, so a packet tracker in the checker can infer packet boundaries from `out_last_o`.

The stimulus driver respects the hold rule. It only re-decides `in_valid_i` after a byte has been taken, and it varies input gaps and output stalls from a shift-register pattern. The streams sweep every non-indicator byte value while hunting, a range of short and zero lengths for all three kinds, and ACL lengths at, just over and far over the limit.

// File: rtl/hci_delin_pkg.sv
// Shared types and helpers for the HCI packet delineator.
// Assumes byte-wide transport and the three packet kinds handled here.
package hci_delin_pkg;

    localparam int BYTE_W  = 8;
    localparam int HDR_MAX = 4;
    localparam int HIDX_W  = 3;

    localparam logic [BYTE_W-1:0] IND_CMD = 8'h01;
    localparam logic [BYTE_W-1:0] IND_ACL = 8'h02;
    localparam logic [BYTE_W-1:0] IND_EVT = 8'h04;

    typedef enum logic [1:0] {
        KIND_CMD = 2'd0,
        KIND_ACL = 2'd1,
        KIND_EVT = 2'd2
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HDR,
        ST_CHECK,
        ST_REPLAY,
        ST_BODY
    } dl_state_e;

    typedef logic [HDR_MAX-1:0][BYTE_W-1:0] hdr_buf_t;

    // Number of header bytes that follow the type indicator for a kind.
    function automatic logic [HIDX_W-1:0] hdr_bytes(input pkt_kind_e k);
        case (k)
            KIND_CMD: return 3'd3;
            KIND_ACL: return 3'd4;
            default:  return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/hci_type_decode.sv
// Classifies a byte as a packet type indicator.
// Purely combinational; assumes only command, ACL and event kinds are legal.
module hci_type_decode
    import hci_delin_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              known_o,
    output pkt_kind_e         kind_o
);

    // Map indicator value to kind; anything else is unknown.
    always_comb begin
        known_o = 1'b1;
        kind_o  = KIND_CMD;
        case (byte_i)
            IND_CMD: kind_o = KIND_CMD;
            IND_ACL: kind_o = KIND_ACL;
            IND_EVT: kind_o = KIND_EVT;
            default: known_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/hci_len_extract.sv
// Pulls the payload length from a collected header and flags oversize ACL data.
// Assumes the header buffer holds the bytes after the indicator, index 0 first.
module hci_len_extract
    import hci_delin_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int MAX_ACL_LEN = 1024
) (
    input  pkt_kind_e        kind_i,
    input  hdr_buf_t         hdr_i,
    output logic [LEN_W-1:0] len_o,
    output logic             oversize_o
);

    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_ACL_LEN);

    // Length field position depends on the kind.
    always_comb begin
        case (kind_i)
            KIND_CMD: len_o = LEN_W'(hdr_i[2]);
            KIND_ACL: len_o = LEN_W'({hdr_i[3], hdr_i[2]});
            default:  len_o = LEN_W'(hdr_i[1]);
        endcase
    end

    // Only the 16-bit ACL length can exceed the limit.
    always_comb oversize_o = (kind_i == KIND_ACL) && (len_o > LIMIT);

endmodule

// File: rtl/hci_byte_counter.sv
// Loadable down-counter of payload bytes still to forward.
// Assumes load and decrement are never requested together.
module hci_byte_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             one_o
);

    logic [CNT_W-1:0] cnt_q;

    // Hold remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Flag the final byte.
    always_comb one_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/hci_pkt_delineator.sv
// Splits an HCI transport byte stream into framed packets.
// Hunts for a type indicator, buffers the header, checks the length, replays
// the header, then passes the payload through. Assumes the upstream holds
// valid and data until accepted.
module hci_pkt_delineator
    import hci_delin_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int MAX_ACL_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_data_o,
    output logic              out_sof_o,
    output logic              out_last_o,
    output logic [1:0]        out_user_o,
    input  logic              out_ready_i,
    output logic              len_err_o
);

    localparam int SEL_W = $clog2(HDR_MAX);

    dl_state_e         state_q;
    pkt_kind_e         kind_q;
    pkt_kind_e         dec_kind;
    logic              dec_known;
    logic [HIDX_W-1:0] hidx_q;
    logic [HIDX_W-1:0] hlast;
    hdr_buf_t          hbuf_q;
    logic [LEN_W-1:0]  pkt_len;
    logic              oversize;
    logic              len_zero;
    logic              rem_one;
    logic              err_q;
    logic              in_fire;
    logic              out_fire;
    logic              hdr_done;
    logic              replay_done;

    hci_type_decode type_dec_i (
        .byte_i  (in_data_i),
        .known_o (dec_known),
        .kind_o  (dec_kind)
    );

    hci_len_extract #(
        .LEN_W       (LEN_W),
        .MAX_ACL_LEN (MAX_ACL_LEN)
    ) len_ext_i (
        .kind_i     (kind_q),
        .hdr_i      (hbuf_q),
        .len_o      (pkt_len),
        .oversize_o (oversize)
    );

    hci_byte_counter #(
        .CNT_W (LEN_W)
    ) rem_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_CHECK),
        .load_val_i (pkt_len),
        .dec_i      ((state_q == ST_BODY) && in_fire),
        .one_o      (rem_one)
    );

    // Handshake and position helpers.
    always_comb begin
        in_fire     = in_valid_i && in_ready_o;
        out_fire    = out_valid_o && out_ready_i;
        hlast       = hdr_bytes(kind_q) - HIDX_W'(1);
        len_zero    = (pkt_len == '0);
        hdr_done    = (state_q == ST_HDR) && in_fire && (hidx_q == hlast);
        replay_done = (state_q == ST_REPLAY) && out_ready_i && (hidx_q == hlast);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            case (state_q)
                ST_HUNT:   if (in_valid_i && dec_known) state_q <= ST_HDR;
                ST_HDR:    if (hdr_done) state_q <= ST_CHECK;
                ST_CHECK:  state_q <= oversize ? ST_HUNT : ST_REPLAY;
                ST_REPLAY: if (replay_done) state_q <= len_zero ? ST_HUNT : ST_BODY;
                ST_BODY:   if (in_fire && rem_one) state_q <= ST_HUNT;
                default:   state_q <= ST_HUNT;
            endcase
        end
    end

    // Latch packet kind when an indicator is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         kind_q <= KIND_CMD;
        else if (state_q == ST_HUNT && in_valid_i && dec_known) kind_q <= dec_kind;
    end

    // Header byte index, reused as replay index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidx_q <= '0;
        end else begin
            case (state_q)
                ST_HUNT:   hidx_q <= '0;
                ST_HDR:    if (in_fire) hidx_q <= hidx_q + HIDX_W'(1);
                ST_CHECK:  hidx_q <= '0;
                ST_REPLAY: if (out_ready_i) hidx_q <= hidx_q + HIDX_W'(1);
                default:   hidx_q <= hidx_q;
            endcase
        end
    end

    // One register per header byte position.
    for (genvar g = 0; g < HDR_MAX; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n)
                hbuf_q[g] <= '0;
            else if (state_q == ST_HDR && in_valid_i && hidx_q == HIDX_W'(g))
                hbuf_q[g] <= in_data_i;
        end
    end

    // Single-cycle error pulse on rejected length.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (state_q == ST_CHECK) && oversize;
    end

    // Port drive: header replay from buffer, payload passed through.
    always_comb begin
        in_ready_o  = 1'b0;
        out_valid_o = 1'b0;
        out_data_o  = in_data_i;
        out_sof_o   = 1'b0;
        out_last_o  = 1'b0;
        case (state_q)
            ST_HUNT, ST_HDR: in_ready_o = 1'b1;
            ST_REPLAY: begin
                out_valid_o = 1'b1;
                out_data_o  = hbuf_q[hidx_q[SEL_W-1:0]];
                out_sof_o   = (hidx_q == '0);
                out_last_o  = (hidx_q == hlast) && len_zero;
            end
            ST_BODY: begin
                in_ready_o  = out_ready_i;
                out_valid_o = in_valid_i;
                out_last_o  = rem_one;
            end
            default: ;
        endcase
        out_user_o = kind_q;
        len_err_o  = err_q;
    end

endmodule

// File: rtl/hci_delin_checker.sv
// Port-level properties of the HCI packet delineator, bound into every instance.
// Assumes upstream holds valid and data until accepted.
module hci_delin_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready_o,
    input logic       out_valid_o,
    input logic [7:0] out_data_o,
    input logic       out_sof_o,
    input logic       out_last_o,
    input logic [1:0] out_user_o,
    input logic       out_ready_i,
    input logic       len_err_o
);

    logic       mid_q;
    logic [1:0] user_q;

    // Track whether a packet is open on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            user_q <= 2'd0;
        end else if (out_valid_o && out_ready_i) begin
            mid_q <= !out_last_o;
            if (out_sof_o) user_q <= out_user_o;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) &&
        $stable(out_sof_o) && $stable(out_last_o) && $stable(out_user_o)));

    assert_no_take_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |-> !in_ready_o);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |=> !len_err_o);

    assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !out_valid_o);

    assert_sof_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !mid_q) |-> out_sof_o);

    assert_sof_inner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && mid_q) |-> !out_sof_o);

    assert_user_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && mid_q) |-> (out_user_o == user_q));

    assert_user_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_user_o != 2'd3));

endmodule

bind hci_pkt_delineator hci_delin_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .out_last_o  (out_last_o),
    .out_user_o  (out_user_o),
    .out_ready_i (out_ready_i),
    .len_err_o   (len_err_o)
);

// File: tb/hci_pkt_delineator_tb_top.sv
// Stream-level bench: builds byte streams and expected frames arithmetically,
// drives them under several gap/stall patterns and compares every output byte.
module hci_pkt_delineator_tb_top;

    localparam int LIMIT_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o;
    logic       out_valid_o;
    logic [7:0] out_data_o;
    logic       out_sof_o;
    logic       out_last_o;
    logic [1:0] out_user_o;
    logic       out_ready_i = 1'b0;
    logic       len_err_o;

    always #4 clk = ~clk;

    hci_pkt_delineator dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .out_sof_o   (out_sof_o),
        .out_last_o  (out_last_o),
        .out_user_o  (out_user_o),
        .out_ready_i (out_ready_i),
        .len_err_o   (len_err_o)
    );

    logic [7:0]  in_q[$];
    logic [12:0] exp_q[$];   // {hdr, user[1:0], sof, last, data[7:0]}
    int ptr = 0, eptr = 0, exp_err = 0, got_err = 0;
    int n_cmp = 0, n_bad = 0, cyc = 0, mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit hold = 0;

    function automatic void push_exp(bit h, logic [1:0] u, bit s, bit l, logic [7:0] d);
        exp_q.push_back({h, u, s, l, d});
    endfunction

    task automatic add_pkt(logic [7:0] ind, logic [1:0] u, logic [31:0] hb, int hn,
                           int plen, int seed);
        in_q.push_back(ind);
        for (int i = 0; i < hn; i++) begin
            in_q.push_back(hb[8*i +: 8]);
            push_exp(1'b1, u, i == 0, (i == hn - 1) && (plen == 0), hb[8*i +: 8]);
        end
        for (int i = 0; i < plen; i++) begin
            logic [7:0] d;
            d = 8'((seed + i * 13) & 255);
            in_q.push_back(d);
            push_exp(1'b0, u, 1'b0, i == plen - 1, d);
        end
    endtask

    // R3: command, opcode lo/hi then 1-byte length
    task automatic add_cmd(logic [15:0] op, int len, int seed);
        add_pkt(8'h01, 2'd0, {8'h00, 8'(len), op[15:8], op[7:0]}, 3, len, seed);
    endtask

    // R4: event, code then 1-byte length
    task automatic add_evt(logic [7:0] code, int len, int seed);
        add_pkt(8'h04, 2'd2, {16'h0000, 8'(len), code}, 2, len, seed);
    endtask

    // R5: ACL, handle lo/hi then little-endian 16-bit length
    task automatic add_acl(logic [15:0] hdl, int len, int seed);
        logic [15:0] l16;
        l16 = 16'(len);
        if (len > 1024) begin
            in_q.push_back(8'h02);
            in_q.push_back(hdl[7:0]);
            in_q.push_back(hdl[15:8]);
            in_q.push_back(l16[7:0]);
            in_q.push_back(l16[15:8]);
            exp_err++;   // R7: error, no output
        end else begin
            add_pkt(8'h02, 2'd1, {l16[15:8], l16[7:0], hdl[15:8], hdl[7:0]}, 4, len, seed);
        end
    endtask

    task automatic fail_line(string req, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!hold) begin
            bit go;
            go = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
            if (ptr < in_q.size() && go) begin
                in_valid_i = 1'b1;
                in_data_i  = in_q[ptr];
            end else begin
                in_valid_i = 1'b0;
            end
        end
        case (mode)
            0:       out_ready_i = 1'b1;
            1:       out_ready_i = lfsr[5] | lfsr[2];
            default: out_ready_i = lfsr[1] & lfsr[4];
        endcase
        #1;
        if (out_valid_o && !out_ready_i) begin
            n_cmp++;
            if (in_ready_o) fail_line("R8", "input taken while output stalled", 1, 0);
        end
        if (out_valid_o && out_ready_i) begin
            n_cmp++;
            if (eptr >= exp_q.size()) begin
                fail_line("R9", "unexpected output byte", int'(out_data_o), 0);
            end else begin
                logic [12:0] e;
                string tag;
                e = exp_q[eptr];
                tag = (e[11:10] == 2'd0) ? "R3" : (e[11:10] == 2'd1) ? "R5" : "R4";
                if (out_data_o != e[7:0])     fail_line(tag, "data", int'(out_data_o), int'(e[7:0]));
                else if (out_user_o != e[11:10]) fail_line(tag, "kind", int'(out_user_o), int'(e[11:10]));
                else if (out_sof_o != e[9])   fail_line("R6", "sof", int'(out_sof_o), int'(e[9]));
                else if (out_last_o != e[8])  fail_line("R6", "last", int'(out_last_o), int'(e[8]));
                else if (e[12] && in_ready_o) fail_line("R10", "input taken during header", 1, 0);
                eptr++;
            end
        end
        if (in_valid_i && in_ready_o) begin
            ptr++;
            hold = 1'b0;
        end else begin
            hold = in_valid_i;
        end
        if (len_err_o) got_err++;
        cyc++;
    endtask

    task automatic run_stream(int m);
        mode = m;
        while ((ptr < in_q.size() || eptr < exp_q.size()) && cyc < LIMIT_CYC) step();
        repeat (20) step();
        n_cmp++;
        if (cyc >= LIMIT_CYC) fail_line("R8", "watchdog expired", cyc, LIMIT_CYC);
        n_cmp++;
        if (eptr != exp_q.size()) fail_line("R9", "frames delivered", eptr, exp_q.size());
        n_cmp++;
        if (got_err != exp_err) fail_line("R7", "length error pulses", got_err, exp_err);
    endtask

    task automatic build(int run);
        // R2: every non-indicator value while hunting
        if (run == 0) begin
            for (int v = 0; v < 256; v++)
                if (v != 1 && v != 2 && v != 4) in_q.push_back(8'(v));
        end
        for (int l = 0; l < 6; l++) begin
            add_cmd(16'h0C00 + 16'(l * 5 + run), l, l * 31 + run);
            in_q.push_back(8'h03);   // R2: junk between packets
            add_evt(8'h0E + 8'(l), l + 1, l * 17 + run);
        end
        add_evt(8'h3E, 0, 0);
        add_cmd(16'hFC01, 255, 9 + run);
        add_acl(16'h0001, 0, 0);
        add_acl(16'h0042, 1, 5);
        in_q.push_back(8'hFF);
        add_acl(16'h0FFF, 2, 77);
        add_acl(16'h0102, 256, 3 + run);
        add_acl(16'h0003, 1025, 0);      // R7: just over limit
        add_evt(8'h13, 3, 40);
        add_acl(16'h0004, 65535, 0);     // R7: far over limit
        add_acl(16'h0005, 1024, 11);     // R7: at limit
        add_cmd(16'h0C03, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_cmp++;
        if (in_ready_o !== 1'b1) fail_line("R1", "in_ready after reset", int'(in_ready_o), 1);
        n_cmp++;
        if (out_valid_o !== 1'b0) fail_line("R1", "out_valid after reset", int'(out_valid_o), 0);
        n_cmp++;
        if (len_err_o !== 1'b0) fail_line("R1", "len_err after reset", int'(len_err_o), 0);
        for (int r = 0; r < 3; r++) begin
            build(r);
            run_stream(r);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule